// File: doc/BRIEF.md
# External Interrupt Arbiter for One Processor Target

This block collects up to 31 level-sensitive interrupt request lines and raises a single interrupt request toward one processor. Every source has a programmable 3-bit priority, a bit in an enable bitmap, and a latched pending bit. A global 3-bit threshold hides every source whose priority does not exceed it. Software sees the block through a plain word-wide register port, with one request strobe, a write flag, a byte offset and write data. Read data comes back combinationally in the same cycle as the request.

An interrupt is serviced in two steps on one shared register. Software reads it to take the best eligible source, and that read moves the source from pending into service. Software later writes the source number back to the same register to finish service. While a source is in service, its input cannot raise a new request. Source number 0 does not exist, and a claim read returning 0 means that nothing was eligible.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every priority, the enable bitmap, the threshold and all pending bits are zero, `irq_o` is low, and a claim read returns 0.
- R2: The priority of source N (1..31) lives at offset 4*N. Only the low 3 bits of a written word are kept, and reads return them zero-extended. Offset 0 always reads 0 and ignores writes.
- R3: The enable bitmap at offset 0x002000 has bit N enabling source N. Bit 0 always reads 0.
- R4: The pending bitmap at offset 0x001000 is read-only and has bit N set while source N has a latched request. Writes to it have no effect.
- R5: The threshold at offset 0x200000 keeps the low 3 bits of a write. A source is eligible only if it is pending, enabled and its priority is strictly greater than the threshold.
- R6: A read of the claim/complete register at offset 0x200004 returns the number of the eligible source with the highest priority. On a priority tie it returns the lowest number, and it returns 0 when no source is eligible.
- R7: A claim read that returns a nonzero number clears that source's pending bit at the closing clock edge and puts the source in service. While the source is in service its pending bit stays 0, even with its input held high.
- R8: Writing the number of an in-service source to offset 0x200004 ends its service at that clock edge. If the input is high at that edge, the pending bit sets at the same edge.
- R9: A completion write carrying 0, a number above 31, or the number of a source not in service changes nothing.
- R10: `irq_o` is registered. It goes high one clock edge after the internal state first holds an eligible source, and goes low one edge after the edge at which the last eligible source was claimed.
- R11: Reads of unmapped offsets return 0, and writes to them change no state.
- R12: A request is latched. A source input that is high for one clock edge leaves its pending bit set after the input drops, until that source is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 31 (bits 31:1) | Level interrupt request of source N on bit N |
| req_i | input | 1 | Register access strobe, one access per cycle |
| wr_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 22 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read strobe, 0 otherwise |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that at most one register access happens per cycle. This means that a claim and a completion can never name the same source in the same cycle, and the port enforces it by construction. They also assume that source inputs and bus signals are stable around the rising clock edge. The bench keeps to this by driving every input on the falling edge, issuing accesses strictly one after another, and releasing the strobe right after each rising edge.

// File: rtl/eic_pkg.sv
package eic_pkg;

    localparam int unsigned DATA_W = 32;

    localparam logic [DATA_W-1:0] OFF_PEND  = 32'h0000_1000;
    localparam logic [DATA_W-1:0] OFF_EN    = 32'h0000_2000;
    localparam logic [DATA_W-1:0] OFF_THR   = 32'h0020_0000;
    localparam logic [DATA_W-1:0] OFF_CLAIM = 32'h0020_0004;

    // Upper end (exclusive) of the per-source priority window
    localparam logic [DATA_W-1:0] PRIO_WIN_END = 32'h0000_1000;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PRIO,
        SEL_PEND,
        SEL_EN,
        SEL_THR,
        SEL_CLAIM
    } reg_sel_e;

endpackage

// File: rtl/eic_cfg_regs.sv
module eic_cfg_regs #(
    parameter int unsigned NSRC   = 31,
    parameter int unsigned PRIO_W = 3,
    localparam int unsigned IDX_W = $clog2(NSRC + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_prio_i,
    input  logic [IDX_W-1:0]           wr_idx_i,
    input  logic                       wr_en_i,
    input  logic                       wr_thr_i,
    input  logic [PRIO_W-1:0]          fld_wdata_i,
    input  logic [NSRC:1]              en_wdata_i,
    output logic [NSRC:1][PRIO_W-1:0]  prio_o,
    output logic [NSRC:1]              en_o,
    output logic [PRIO_W-1:0]          thr_o
);

    typedef struct packed {
        logic [NSRC:1][PRIO_W-1:0] prio;
        logic [NSRC:1]             en;
        logic [PRIO_W-1:0]         thr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_prio_i) begin
            for (int k = 1; k <= NSRC; k++) begin
                if (wr_idx_i == IDX_W'(k)) cfg_d.prio[k] = fld_wdata_i;
            end
        end
        if (wr_en_i)  cfg_d.en  = en_wdata_i;
        if (wr_thr_i) cfg_d.thr = fld_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign prio_o = cfg_q.prio;
    assign en_o   = cfg_q.en;
    assign thr_o  = cfg_q.thr;

    // R5: a threshold write lands its low field at the next edge
    a_r5_thr_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_thr_i |=> thr_o == $past(fld_wdata_i));

    // R3: an enable write replaces the bitmap
    a_r3_en_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> en_o == $past(en_wdata_i));

    // R2: priority of a source changes only through its own write
    for (genvar k = 1; k <= NSRC; k++) begin : g_prio_chk
        a_r2_prio_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_prio_i && wr_idx_i == IDX_W'(k)) |=> $stable(prio_o[k]));
    end

endmodule

// File: rtl/eic_gateway.sv
module eic_gateway #(
    parameter int unsigned NSRC = 31,
    localparam int unsigned IDX_W = $clog2(NSRC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC:1]     src_i,
    input  logic              claim_i,
    input  logic [IDX_W-1:0]  claim_id_i,
    input  logic              cpl_i,
    input  logic [IDX_W-1:0]  cpl_id_i,
    output logic [NSRC:1]     pend_o
);

    typedef struct packed {
        logic [NSRC:1] pend;
        logic [NSRC:1] busy;
    } gw_t;

    gw_t gw_d, gw_q;
    logic [NSRC:1] take_hit;
    logic [NSRC:1] done_hit;

    always_comb begin
        for (int k = 1; k <= NSRC; k++) begin
            take_hit[k] = claim_i && (claim_id_i == IDX_W'(k));
            done_hit[k] = cpl_i   && (cpl_id_i   == IDX_W'(k));
        end
        gw_d.busy = (gw_q.busy & ~done_hit) | take_hit;
        gw_d.pend = (gw_q.pend & ~take_hit) | (src_i & ~gw_d.busy);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gw_q <= '0;
        else        gw_q <= gw_d;
    end

    assign pend_o = gw_q.pend;

    for (genvar k = 1; k <= NSRC; k++) begin : g_gw_chk
        // R7: a claim moves the source from pending into service
        a_r7_claim_moves: assert property (@(posedge clk) disable iff (!rst_n)
            (claim_i && claim_id_i == IDX_W'(k)) |=> (!gw_q.pend[k] && gw_q.busy[k]));
        // R7: no new request while in service
        a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            gw_q.busy[k] |-> !gw_q.pend[k]);
        // R9: completion of a source not in service leaves it idle
        a_r9_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
            (cpl_i && cpl_id_i == IDX_W'(k) && !gw_q.busy[k]) |=> !gw_q.busy[k]);
        // R12: a latched request survives until claimed
        a_r12_latched: assert property (@(posedge clk) disable iff (!rst_n)
            (gw_q.pend[k] && !(claim_i && claim_id_i == IDX_W'(k))) |=> gw_q.pend[k]);
    end

endmodule

// File: rtl/eic_arbiter.sv
module eic_arbiter #(
    parameter int unsigned NSRC   = 31,
    parameter int unsigned PRIO_W = 3,
    localparam int unsigned IDX_W = $clog2(NSRC + 1)
) (
    input  logic [NSRC:1]             pend_i,
    input  logic [NSRC:1]             en_i,
    input  logic [NSRC:1][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]         thr_i,
    output logic [NSRC:1]             elig_o,
    output logic [IDX_W-1:0]          win_id_o
);

    logic [PRIO_W-1:0] best_prio;

    always_comb begin
        for (int k = 1; k <= NSRC; k++) begin
            elig_o[k] = pend_i[k] && en_i[k] && (prio_i[k] > thr_i);
        end
        // Scan from the top number down; ">=" lets a lower number take a tie
        best_prio = '0;
        win_id_o  = '0;
        for (int i = NSRC; i >= 1; i--) begin
            if (elig_o[i] && (prio_i[i] >= best_prio)) begin
                best_prio = prio_i[i];
                win_id_o  = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
    parameter int unsigned NSRC   = 31,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned ADDR_W = 22,
    localparam int unsigned IDX_W = $clog2(NSRC + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSRC:1]             src_i,
    input  logic                      req_i,
    input  logic                      wr_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [eic_pkg::DATA_W-1:0] wdata_i,
    output logic [eic_pkg::DATA_W-1:0] rdata_o,
    output logic                      irq_o
);
    import eic_pkg::*;

    typedef struct packed {
        logic irq;
    } top_t;

    top_t top_d, top_q;

    reg_sel_e                  sel;
    logic [DATA_W-1:0]         addr_w;
    logic [IDX_W-1:0]          prio_idx;
    logic [NSRC:1][PRIO_W-1:0] prio;
    logic [NSRC:1]             en;
    logic [PRIO_W-1:0]         thr;
    logic [NSRC:1]             pend;
    logic [NSRC:1]             elig;
    logic [IDX_W-1:0]          win_id;
    logic                      claim_go;
    logic                      cpl_go;
    logic                      rd_go;

    // Offset decode
    always_comb begin
        addr_w   = DATA_W'(addr_i);
        sel      = SEL_NONE;
        prio_idx = '0;
        if (addr_w < PRIO_WIN_END && addr_w[1:0] == 2'b00) begin
            for (int k = 1; k <= NSRC; k++) begin
                if (addr_w[DATA_W-1:2] == (DATA_W-2)'(k)) begin
                    sel      = SEL_PRIO;
                    prio_idx = IDX_W'(k);
                end
            end
        end else if (addr_w == OFF_PEND) begin
            sel = SEL_PEND;
        end else if (addr_w == OFF_EN) begin
            sel = SEL_EN;
        end else if (addr_w == OFF_THR) begin
            sel = SEL_THR;
        end else if (addr_w == OFF_CLAIM) begin
            sel = SEL_CLAIM;
        end
    end

    assign rd_go    = req_i && !wr_i;
    assign claim_go = rd_go && (sel == SEL_CLAIM) && (win_id != '0);
    assign cpl_go   = req_i && wr_i && (sel == SEL_CLAIM) &&
                      (wdata_i <= DATA_W'(NSRC));

    eic_cfg_regs #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_prio_i   (req_i && wr_i && sel == SEL_PRIO),
        .wr_idx_i    (prio_idx),
        .wr_en_i     (req_i && wr_i && sel == SEL_EN),
        .wr_thr_i    (req_i && wr_i && sel == SEL_THR),
        .fld_wdata_i (wdata_i[PRIO_W-1:0]),
        .en_wdata_i  (wdata_i[NSRC:1]),
        .prio_o      (prio),
        .en_o        (en),
        .thr_o       (thr)
    );

    eic_gateway #(.NSRC(NSRC)) u_gw (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .claim_i    (claim_go),
        .claim_id_i (win_id),
        .cpl_i      (cpl_go),
        .cpl_id_i   (wdata_i[IDX_W-1:0]),
        .pend_o     (pend)
    );

    eic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
        .pend_i   (pend),
        .en_i     (en),
        .prio_i   (prio),
        .thr_i    (thr),
        .elig_o   (elig),
        .win_id_o (win_id)
    );

    // Read data mux
    always_comb begin
        rdata_o = '0;
        if (rd_go) begin
            unique case (sel)
                SEL_PRIO: begin
                    for (int k = 1; k <= NSRC; k++) begin
                        if (prio_idx == IDX_W'(k)) rdata_o = DATA_W'(prio[k]);
                    end
                end
                SEL_PEND:  rdata_o = DATA_W'({pend, 1'b0});
                SEL_EN:    rdata_o = DATA_W'({en, 1'b0});
                SEL_THR:   rdata_o = DATA_W'(thr);
                SEL_CLAIM: rdata_o = DATA_W'(win_id);
                default:   rdata_o = '0;
            endcase
        end
    end

    always_comb begin
        top_d     = top_q;
        top_d.irq = |elig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign irq_o = top_q.irq;

    // R10: request line follows the eligible set one edge later
    a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (|elig) |=> irq_o);
    a_r10_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !(|elig) |=> !irq_o);

    // R6: nothing eligible means no winner
    a_r6_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(|elig) |-> win_id == '0);

    for (genvar k = 1; k <= NSRC; k++) begin : g_arb_chk
        // R5: eligibility needs priority above threshold
        a_r5_above_thr: assert property (@(posedge clk) disable iff (!rst_n)
            elig[k] |-> (prio[k] > thr && en[k] && pend[k]));
        // R6: no eligible source beats the winner
        a_r6_best_wins: assert property (@(posedge clk) disable iff (!rst_n)
            elig[k] |-> (win_id != '0 &&
                        (prio[k] < prio[win_id] ||
                         (prio[k] == prio[win_id] && IDX_W'(k) >= win_id))));
    end

endmodule

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;

    localparam int CLK_NS = 10;
    localparam int NSRC   = 31;

    localparam logic [21:0] A_PEND  = 22'h001000;
    localparam logic [21:0] A_EN    = 22'h002000;
    localparam logic [21:0] A_THR   = 22'h200000;
    localparam logic [21:0] A_CLAIM = 22'h200004;

    typedef struct packed {
        logic [31:0] src;
        logic [2:0]  thr;
        logic [7:0]  id;
    } vec_t;

    // Priorities used: 1->2, 2->5, 3->5, 5->7, 10->1, 31->3, others 0
    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{32'h0000_0002, 3'd0, 8'd1},
        '{32'h0000_0402, 3'd0, 8'd1},
        '{32'h0000_000C, 3'd0, 8'd2},
        '{32'h0000_0028, 3'd0, 8'd5},
        '{32'h8000_0402, 3'd2, 8'd31},
        '{32'h0000_0024, 3'd7, 8'd0},
        '{32'h0000_0010, 3'd0, 8'd0},
        '{32'h0000_0400, 3'd1, 8'd0},
        '{32'h8000_000C, 3'd4, 8'd2},
        '{32'h8000_0020, 3'd6, 8'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NSRC:1] src = '0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [21:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    ext_irq_ctrl u_ext_irq_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src),
        .req_i   (req),
        .wr_i    (wr),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_rd(input logic [21:0] a, output logic [31:0] d);
        @(negedge clk);
        req = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(posedge clk);
        #1 req = 1'b0;
    endtask

    task automatic bus_wr(input logic [21:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 req = 1'b0; wr = 1'b0;
    endtask

    task automatic drain();
        logic [31:0] id;
        for (int n = 0; n < 40; n++) begin
            bus_rd(A_CLAIM, id);
            if (id == 0) break;
            bus_wr(A_CLAIM, id);
        end
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1 chk("R1 irq", {31'b0, irq}, 32'd0);
        bus_rd(22'h000004, d);  chk("R1 prio1", d, 32'd0);
        bus_rd(A_EN, d);        chk("R1 enable", d, 32'd0);
        bus_rd(A_PEND, d);      chk("R1 pending", d, 32'd0);
        bus_rd(A_THR, d);       chk("R1 threshold", d, 32'd0);
        bus_rd(A_CLAIM, d);     chk("R1 claim", d, 32'd0);

        // R2: priority fields, upper bits dropped, offset 0 dead
        bus_wr(22'h000004, 32'hFFFF_FFFA);
        bus_rd(22'h000004, d);  chk("R2 prio1 masked", d, 32'd2);
        bus_wr(22'h000000, 32'd7);
        bus_rd(22'h000000, d);  chk("R2 prio0 zero", d, 32'd0);
        bus_wr(22'h000008, 32'd5);
        bus_wr(22'h00000C, 32'd5);
        bus_wr(22'h000014, 32'd7);
        bus_wr(22'h000028, 32'd1);
        bus_wr(22'h00007C, 32'd3);
        bus_rd(22'h00007C, d);  chk("R2 prio31", d, 32'd3);

        // R3: enable bitmap, bit 0 dead
        bus_wr(A_EN, 32'hFFFF_FFFF);
        bus_rd(A_EN, d);        chk("R3 enable", d, 32'hFFFF_FFFE);

        // R5: threshold keeps the low field
        bus_wr(A_THR, 32'hFFFF_FFFD);
        bus_rd(A_THR, d);       chk("R5 threshold masked", d, 32'd5);

        // Table: R5 masking, R6 arbitration, R10 request line
        for (int v = 0; v < NVEC; v++) begin
            bus_wr(A_THR, 32'(VEC[v].thr));
            @(negedge clk);
            src = VEC[v].src[NSRC:1];
            @(posedge clk);
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("R10 irq vec%0d", v), {31'b0, irq}, {31'b0, VEC[v].id != 0});
            bus_rd(A_CLAIM, d);
            chk($sformatf("R6 R5 claim vec%0d", v), d, 32'(VEC[v].id));
            if (d != 0) bus_wr(A_CLAIM, d);
            @(negedge clk);
            src = '0;
            bus_wr(A_THR, 32'd0);
            drain();
        end
        // Source 4 (priority 0) stays latched from here on

        // R12: one-edge pulse stays latched
        @(negedge clk); src[10] = 1'b1;
        @(negedge clk); src[10] = 1'b0;
        bus_rd(A_PEND, d);      chk("R12 pulse latched", d, 32'h0000_0410);
        // R10: claim edge, irq drops one edge later
        bus_rd(A_CLAIM, d);     chk("R6 single", d, 32'd10);
        chk("R10 irq lag", {31'b0, irq}, 32'd1);
        @(posedge clk); #1 chk("R10 irq fall", {31'b0, irq}, 32'd0);
        bus_wr(A_CLAIM, 32'd10);

        // R7: in service blocks re-request
        @(negedge clk); src[2] = 1'b1;
        bus_rd(A_CLAIM, d);     chk("R7 claim", d, 32'd2);
        bus_rd(A_PEND, d);      chk("R7 pending cleared", d, 32'h0000_0010);
        bus_rd(A_CLAIM, d);     chk("R7 no reclaim", d, 32'd0);

        // R9: stray completions
        bus_wr(A_CLAIM, 32'd3);
        bus_wr(A_CLAIM, 32'd0);
        bus_wr(A_CLAIM, 32'd34);
        bus_rd(A_PEND, d);      chk("R9 stray ignored", d, 32'h0000_0010);

        // R8: completion lets held input re-latch at once
        bus_wr(A_CLAIM, 32'd2);
        bus_rd(A_PEND, d);      chk("R8 relatch", d, 32'h0000_0014);
        @(negedge clk); src = '0;
        bus_rd(A_CLAIM, d);     chk("R8 reclaim", d, 32'd2);
        bus_wr(A_CLAIM, 32'd2);

        // R4: pending is read-only
        bus_wr(A_PEND, 32'h0);
        bus_rd(A_PEND, d);      chk("R4 write ignored", d, 32'h0000_0010);

        // R11: unmapped offsets
        bus_wr(22'h003000, 32'h0);
        bus_rd(A_EN, d);        chk("R11 enable kept", d, 32'hFFFF_FFFE);
        bus_rd(22'h003000, d);  chk("R11 read zero", d, 32'd0);
        bus_rd(22'h200008, d);  chk("R11 read zero high", d, 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule